// File: doc/BRIEF.md
# Five-port I2C hub forwarding core

This block merges five I2C segments into one logical bus, with SDA and SCL handled by two identical and independent forwarding paths. Each port offers a sampled line input and an active-high pull-down request. The request is meant to drive an open-drain pad, so the physical line is the wired-AND of every device on that segment and the hub's own pull-down. Port 0 always takes part and normally hosts the primary master. Ports 1 to 4 each have an active-high enable, and the block adopts an enable change only while the bus is quiet.

Every line path is a small state machine with three states. In `LN_IDLE` it waits for a LOW on any active port. `LN_IDLE -> LN_FWD` fires when such a LOW appears. The lowest-numbered low port becomes the single owner, and every other active port is pulled low. `LN_FWD -> LN_HOLD` fires when the owner's synchronized input reads HIGH. All pull-downs are then released for `SYNC_STAGES+1` cycles, and during that time any LOW is ignored. This keeps the hub's own release, seen late through the synchronizers, from being taken as a new external LOW. `LN_HOLD -> LN_IDLE` fires when the hold count reaches zero. A port that the hub is pulling low can never become owner, so the hub cannot hold a line low by itself. A device that is still stretching the clock on another port is picked up as the new owner right after the hold.

The enable controller has two states. `EN_BUSY` counts consecutive quiet cycles. A cycle is quiet when both line paths are in `LN_IDLE` and both lines read HIGH on every port that is active or requested. After `IDLE_CYC` quiet cycles, `EN_BUSY -> EN_IDLE`. In `EN_IDLE` the requested enables are copied into the active set on every quiet cycle. Any non-quiet cycle causes `EN_IDLE -> EN_BUSY`, and in `EN_BUSY` a non-quiet cycle also clears the count.

Top module: `i2c_hub_core`

## Requirements
- R1: A LOW that appears on an active port while that line is idle makes the pull-down request rise on every other active port 3 clock edges after the input changes (2 synchronizer edges plus 1 state edge). The pull-down of the port holding the LOW stays at 0.
- R2: When the owning port's input returns HIGH, all pull-down requests on that line fall 3 edges later. They then stay at 0 for at least `SYNC_STAGES+1` cycles.
- R3: The hub never pulls every active port of a line low at once. Once all external devices let go, all pull-down requests return to 0 and stay at 0.
- R4: A LOW that another active port still holds after the owner lets go (a stretch) makes that port the new owner. Its forwarding begins 7 edges after the original owner's release with the default parameters.
- R5: When several active ports go LOW in the same cycle, the lowest-numbered one becomes owner. Every other active port, including the other low ones, is pulled low.
- R6: An inactive port (bit i-1 of `port_en` not yet applied, for port i from 1 to 4) is ignored. Its LOW forwards nothing, and its pull-down request is never raised.
- R7: Port 0 is active at all times and has no enable.
- R8: A change of `port_en` stays pending while the bus is busy. It takes effect only after `IDLE_CYC` consecutive quiet cycles, and never while a line path is outside `LN_IDLE`.
- R9: SDA and SCL are independent. A LOW on one line never raises a pull-down on the other.
- R10: After reset, all pull-down requests are 0 and ports 1 to 4 are inactive until the first enable adoption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | N_PORTS | Sampled SCL line level per port (bit i = port i) |
| sda_in | input | N_PORTS | Sampled SDA line level per port (bit i = port i) |
| port_en | input | N_PORTS-1 | Requested enable, bit i-1 for port i (ports 1 to 4) |
| scl_pd | output | N_PORTS | SCL pull-down request per port, 1 = drive low |
| sda_pd | output | N_PORTS | SDA pull-down request per port, 1 = drive low |

## Verification
The bench changes its external pull-downs on the falling clock edge. The forwarded request is due on the third rising edge after that, so every forwarding and release check first confirms the output is unchanged after the second edge and then checks the expected value after the third. A stretch handover is due 7 edges after the owner releases: the bench checks 0 after edges 3 and 6 and the new owner's pattern after edge 7. Enable changes have a variable adoption time, so the bench allows a fixed margin well beyond `IDLE_CYC` plus synchronizer depth. Pending enables are checked while a LOW is being held, which is the moment they must not be adopted.

// File: rtl/hub_pkg.sv
package hub_pkg;
    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_FWD  = 2'd1,
        LN_HOLD = 2'd2
    } line_state_e;

    typedef enum logic {
        EN_BUSY = 1'b0,
        EN_IDLE = 1'b1
    } en_state_e;
endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= {W{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hub_line.sv
module hub_line
    import hub_pkg::*;
#(
    parameter int N           = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_s,
    input  logic [N-1:0] act,
    output logic [N-1:0] pd,
    output logic         idle
);
    localparam int HOLD_CYC = SYNC_STAGES + 1;
    localparam int IW       = (N > 1) ? $clog2(N) : 1;
    localparam int HW       = $clog2(HOLD_CYC + 1);

    line_state_e    st, st_nx;
    logic [IW-1:0]  own, own_nx, pick;
    logic [HW-1:0]  hcnt, hcnt_nx;
    logic [N-1:0]   low_act;

    assign low_act = act & ~line_s;

    // lowest-numbered low active port
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (low_act[i]) pick = IW'(i);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= LN_IDLE;
            own  <= '0;
            hcnt <= '0;
        end else begin
            st   <= st_nx;
            own  <= own_nx;
            hcnt <= hcnt_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx   = st;
        own_nx  = own;
        hcnt_nx = hcnt;
        unique case (st)
            LN_IDLE: begin
                if (|low_act) begin
                    st_nx  = LN_FWD;
                    own_nx = pick;
                end
            end
            LN_FWD: begin
                if (!low_act[own]) begin
                    st_nx   = LN_HOLD;
                    hcnt_nx = HW'(HOLD_CYC - 1);
                end
            end
            LN_HOLD: begin
                if (hcnt == '0) st_nx = LN_IDLE;
                else            hcnt_nx = hcnt - 1'b1;
            end
            default: st_nx = LN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pd   = '0;
        idle = 1'b0;
        unique case (st)
            LN_IDLE: idle = 1'b1;
            LN_FWD:  pd   = act & ~(N'(1) << own);
            LN_HOLD: pd   = '0;
            default: pd   = '0;
        endcase
    end
endmodule

// File: rtl/hub_en_ctrl.sv
module hub_en_ctrl
    import hub_pkg::*;
#(
    parameter int N        = 5,
    parameter int IDLE_CYC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-2:0] en_req,
    input  logic [N-1:0] scl_s,
    input  logic [N-1:0] sda_s,
    input  logic         scl_idle,
    input  logic         sda_idle,
    output logic [N-2:0] en_act
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    en_state_e      st, st_nx;
    logic [CW-1:0]  cnt, cnt_nx;
    logic [N-1:0]   watch;
    logic           quiet;

    assign watch = {en_req | en_act, 1'b1};
    assign quiet = scl_idle && sda_idle && (&((scl_s & sda_s) | ~watch));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= EN_BUSY;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            EN_BUSY: begin
                if (!quiet)                           cnt_nx = '0;
                else if (cnt == CW'(IDLE_CYC - 1))    st_nx  = EN_IDLE;
                else                                  cnt_nx = cnt + 1'b1;
            end
            EN_IDLE: begin
                if (!quiet) begin
                    st_nx  = EN_BUSY;
                    cnt_nx = '0;
                end
            end
            default: st_nx = EN_BUSY;
        endcase
    end

    // output register: adopt requests only on a quiet idle cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      en_act <= '0;
        else if (st == EN_IDLE && quiet) en_act <= en_req;
    end
endmodule

// File: rtl/i2c_hub_core.sv
module i2c_hub_core #(
    parameter int N_PORTS     = 5,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYC    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] scl_in,
    input  logic [N_PORTS-1:0] sda_in,
    input  logic [N_PORTS-2:0] port_en,
    output logic [N_PORTS-1:0] scl_pd,
    output logic [N_PORTS-1:0] sda_pd
);
    localparam int N_EN  = N_PORTS - 1;
    localparam int N_LN  = 2;

    logic [2*N_PORTS-1:0] lines_s;
    logic [N_PORTS-1:0]   scl_s, sda_s, act_mask;
    logic [N_EN-1:0]      en_req, en_act;
    logic [N_PORTS-1:0]   ln_s  [N_LN];
    logic [N_PORTS-1:0]   ln_pd [N_LN];
    logic                 ln_idle [N_LN];
    logic                 scl_idle, sda_idle;

    hub_sync #(.W(2*N_PORTS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ln (
        .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(lines_s)
    );

    hub_sync #(.W(N_EN), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .d(port_en), .q(en_req)
    );

    assign scl_s    = lines_s[N_PORTS-1:0];
    assign sda_s    = lines_s[2*N_PORTS-1:N_PORTS];
    assign act_mask = {en_act, 1'b1};
    assign ln_s[0]  = scl_s;
    assign ln_s[1]  = sda_s;

    for (genvar g = 0; g < N_LN; g++) begin : g_line
        hub_line #(.N(N_PORTS), .SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk(clk), .rst_n(rst_n), .line_s(ln_s[g]), .act(act_mask),
            .pd(ln_pd[g]), .idle(ln_idle[g])
        );
    end

    assign scl_pd   = ln_pd[0];
    assign sda_pd   = ln_pd[1];
    assign scl_idle = ln_idle[0];
    assign sda_idle = ln_idle[1];

    hub_en_ctrl #(.N(N_PORTS), .IDLE_CYC(IDLE_CYC)) u_en (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .scl_s(scl_s), .sda_s(sda_s),
        .scl_idle(scl_idle), .sda_idle(sda_idle), .en_act(en_act)
    );
endmodule

// File: rtl/hub_chk.sv
module hub_chk #(
    parameter int N_PORTS = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PORTS-1:0] scl_pd,
    input logic [N_PORTS-1:0] sda_pd,
    input logic [N_PORTS-1:0] act,
    input logic [N_PORTS-1:0] scl_s,
    input logic [N_PORTS-1:0] sda_s,
    input logic               scl_idle,
    input logic               sda_idle,
    input logic [N_PORTS-2:0] en_act
);
    AST_SCL_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((|scl_pd) && !$past(|scl_pd)) |-> $past(|(act & ~scl_s))); // R1
    AST_SDA_START_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sda_pd) && !$past(|sda_pd)) |-> $past(|(act & ~sda_s))); // R1
    AST_SCL_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|scl_pd) |=> !(|scl_pd)); // R2
    AST_SDA_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|sda_pd) |=> !(|sda_pd)); // R2
    AST_SCL_NEVER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pd & act) != act); // R3
    AST_SDA_NEVER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pd & act) != act); // R3
    AST_SCL_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pd & ~act) == '0); // R6
    AST_SDA_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pd & ~act) == '0); // R6
    AST_EN_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act != $past(en_act)) |-> $past(scl_idle && sda_idle)); // R8
endmodule

bind i2c_hub_core hub_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_pd(scl_pd), .sda_pd(sda_pd), .act(act_mask),
    .scl_s(scl_s), .sda_s(sda_s), .scl_idle(scl_idle), .sda_idle(sda_idle),
    .en_act(en_act)
);

// File: tb/i2c_hub_core_tb.sv
module i2c_hub_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ext_scl = '0, ext_sda = '0;
    logic [3:0] port_en = 4'b1111;
    logic [4:0] scl_in, sda_in, scl_pd, sda_pd;
    int         errors = 0, checks = 0;

    always #2 clk = ~clk;

    // wired-AND with weak pull-ups
    assign scl_in = ~(ext_scl | scl_pd);
    assign sda_in = ~(ext_sda | sda_pd);

    i2c_hub_core u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .port_en(port_en), .scl_pd(scl_pd), .sda_pd(sda_pd)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic pull(input int ln, input int p, input logic v);
        if (ln == 0) ext_scl[p] = v;
        else         ext_sda[p] = v;
    endtask

    function automatic logic [4:0] pd_of(input int ln);
        return (ln == 0) ? scl_pd : sda_pd;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(2);
        check("R10 scl reset", scl_pd, 5'b00000);
        check("R10 sda reset", sda_pd, 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: only port 0 active straight after reset
        pull(0, 0, 1'b1);
        tick(3);
        check("R10 port0 alone", scl_pd, 5'b00000);
        tick(20);
        check("R8 pending while held", scl_pd, 5'b00000);
        pull(0, 0, 1'b0);
        tick(24);
        pull(0, 2, 1'b1);
        tick(3);
        check("R8 applied after idle", scl_pd, 5'b11011);
        pull(0, 2, 1'b0);
        tick(3);
        check("R2 release", scl_pd, 5'b00000);
        tick(6);

        // exhaustive sweep: enable masks x lines x source ports
        for (int m = 0; m < 16; m++) begin
            logic [4:0] act;
            port_en = 4'(m);
            act = {4'(m), 1'b1};
            tick(24);
            for (int ln = 0; ln < 2; ln++) begin
                for (int s = 0; s < 5; s++) begin
                    logic [4:0] exp;
                    string      tag;
                    exp = act[s] ? (act & ~(5'b1 << s)) : 5'b00000;
                    tag = (s == 0) ? "R7" : (act[s] ? "R1" : "R6");
                    pull(ln, s, 1'b1);
                    tick(2);
                    check({tag, " not yet due"}, pd_of(ln), 5'b00000);
                    tick(1);
                    check({tag, " forward"}, pd_of(ln), exp);
                    check("R9 other line", pd_of(1 - ln), 5'b00000);
                    pull(ln, s, 1'b0);
                    tick(3);
                    check("R2 release", pd_of(ln), 5'b00000);
                    tick(6);
                end
            end
        end

        // R5 priority and R4 stretch handover (all enabled)
        port_en = 4'b1111;
        tick(24);
        pull(0, 1, 1'b1);
        pull(0, 3, 1'b1);
        tick(3);
        check("R5 lowest wins", scl_pd, 5'b11101);
        pull(0, 1, 1'b0);
        tick(3);
        check("R2 drop on owner release", scl_pd, 5'b00000);
        tick(3);
        check("R2 hold window", scl_pd, 5'b00000);
        tick(1);
        check("R4 stretch picked up", scl_pd, 5'b10111);
        pull(0, 3, 1'b0);
        tick(3);
        check("R3 no self hold", scl_pd, 5'b00000);
        tick(12);
        check("R3 stays released", scl_pd, 5'b00000);

        // R3 on SDA with long hold
        pull(1, 2, 1'b1);
        tick(15);
        check("R1 sda held", sda_pd, 5'b11011);
        pull(1, 2, 1'b0);
        tick(3);
        check("R3 sda release", sda_pd, 5'b00000);
        tick(12);
        check("R3 sda stays released", sda_pd, 5'b00000);

        // R6: port disabled while busy keeps forwarding until idle
        pull(0, 0, 1'b1);
        port_en = 4'b1110;
        tick(20);
        check("R8 disable pending", scl_pd, 5'b11110);
        pull(0, 0, 1'b0);
        tick(24);
        pull(0, 1, 1'b1);
        tick(3);
        check("R6 disabled source", scl_pd, 5'b00000);
        pull(0, 1, 1'b0);
        tick(6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule